// File: doc/BRIEF.md
# Light-Level Threshold Alarm with Persistence Filter

This block watches the 16-bit unfiltered (clear) light result that a sensing engine produces at the end of each integration phase. Every accepted result is compared against a programmable lower and upper limit. A run of consecutive out-of-range results is counted. When the run reaches the length selected by a 4-bit persistence code, a sticky alarm flag is set.

The flag stays set until a one-cycle clear pulse arrives. The flag itself is always visible. A separate active-low, open-drain style pull-down enable drives the shared interrupt line only when the alarm output is enabled.

Results arrive on a valid/ready stream. The block has no back-pressure: `smp_ready` is held high at all times. A result is consumed on every clock edge where `smp_valid` is high, and nothing is consumed when it is low. The limits, the persistence code, the enable and the clear are plain control pins.

Top module: `lux_alarm`

## Requirements
- R1: `smp_ready` is 1 in every cycle after reset. A result is consumed only on an edge where `smp_valid` is 1. Cycles without `smp_valid` change neither the run count nor the flag.
- R2: When `lim_lo <= lim_hi`, a result is out of range if it is strictly below `lim_lo` or strictly above `lim_hi`. Values equal to a limit are in range.
- R3: When `lim_lo > lim_hi`, only the below-`lim_lo` test applies, and a result above `lim_hi` alone is in range.
- R4: Persistence code 0 sets the flag on every consumed result, in range or not.
- R5: Persistence codes 1, 2 and 3 set the flag when the run of consecutive out-of-range results reaches 1, 2 or 3.
- R6: Persistence codes 4 to 15 require a run of 5 × (code − 3), that is 5, 10, … up to 60.
- R7: Any consumed in-range result resets the run count to zero.
- R8: Once set, `irq_flag` stays at 1 until `irq_clr` is 1 on a clock edge, which clears it for that edge only.
- R9: If a result that triggers the alarm is consumed on the same edge as `irq_clr`, the flag ends up at 1.
- R10: `irq_flag` reflects the latched alarm regardless of `irq_en`. `irq_od_n` is 0 (pulling the line low) exactly when the flag is 1 and `irq_en` is 1, and is 1 otherwise.
- R11: The flag rises on the same clock edge that consumes the triggering result, so it is visible in the cycle after the strobe.
- R12: After reset, `irq_flag` is 0, `irq_od_n` is 1 and the run count is zero.
- R13: The run count saturates at 63 and never wraps. Under code 15, every out-of-range result after the 60th in an unbroken run sets the flag again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | End-of-integration strobe; result on `smp_level` is valid |
| smp_ready | output | 1 | Always 1; the block never stalls |
| smp_level | input | 16 | Clear-channel result |
| lim_lo | input | 16 | Lower limit |
| lim_hi | input | 16 | Upper limit |
| persist_code | input | 4 | Encoded run length (see R4 to R6) |
| irq_en | input | 1 | Enables the pull-down on the interrupt line |
| irq_clr | input | 1 | One-cycle alarm clear |
| irq_flag | output | 1 | Latched alarm status |
| irq_od_n | output | 1 | Active-low pull-down enable for the shared interrupt line |

## Verification
The bench targets limits set one count either side of each result, to catch a comparison written as `<=` instead of `<`. It uses crossed limits, where a design that still applied the upper test would raise false alarms. A run of 59 then 60 at code 15 exposes a wrong code-to-count map or a count that wraps and goes silent. The bench also checks a clear that coincides with a trigger, where losing the trigger drops a real alarm. Finally, it toggles the enable while the flag is held, to catch a status bit that wrongly follows the enable.

// File: rtl/lux_alarm_pkg.sv
package lux_alarm_pkg;
  localparam int DATA_W  = 16;
  localparam int PCODE_W = 4;
  localparam int CNT_W   = 6;
endpackage

// File: rtl/lux_range_cmp.sv
module lux_range_cmp #(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] level,
  input  logic [DATA_W-1:0] lo,
  input  logic [DATA_W-1:0] hi,
  output logic              out_of_range
);
  logic below, above, crossed;
  always_comb begin
    below   = level < lo;
    above   = level > hi;
    crossed = lo > hi;
    // lower test first; crossed limits suppress the upper test
    out_of_range = below | (above & ~crossed);
  end
endmodule

// File: rtl/lux_persist_map.sv
module lux_persist_map #(
  parameter int PCODE_W = 4,
  parameter int CNT_W   = 6
) (
  input  logic [PCODE_W-1:0] code,
  output logic [CNT_W-1:0]   target
);
  localparam int LINEAR_TOP = 3;
  localparam int STEP       = 5;
  int scaled;
  always_comb begin
    scaled = (int'(code) - LINEAR_TOP) * STEP;
    if (int'(code) <= LINEAR_TOP) target = CNT_W'(code);
    else                          target = CNT_W'(scaled);
  end
endmodule

// File: rtl/lux_streak.sv
module lux_streak #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic             oor,
  input  logic [CNT_W-1:0] target,
  output logic             reached
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  logic [CNT_W-1:0] cnt, cnt_nx;

  always_comb begin
    cnt_nx  = (cnt == CNT_MAX) ? cnt : cnt + 1'b1;
    reached = oor && (cnt_nx >= target);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (take) cnt <= oor ? cnt_nx : '0;
  end

  AST_STREAK_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !oor) |=> (cnt == '0)); // R7
  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (take && oor && cnt == CNT_MAX) |=> (cnt == CNT_MAX)); // R13
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(cnt)); // R1
endmodule

// File: rtl/lux_alarm.sv
module lux_alarm
  import lux_alarm_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int CW = CNT_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               smp_valid,
  output logic               smp_ready,
  input  logic [DW-1:0]      smp_level,
  input  logic [DW-1:0]      lim_lo,
  input  logic [DW-1:0]      lim_hi,
  input  logic [PCODE_W-1:0] persist_code,
  input  logic               irq_en,
  input  logic               irq_clr,
  output logic               irq_flag,
  output logic               irq_od_n
);
  logic          oor, reached, fire, take;
  logic [CW-1:0] target;

  assign smp_ready = 1'b1;
  assign take      = smp_valid & smp_ready;

  lux_range_cmp #(.DATA_W(DW)) u_cmp (
    .level(smp_level), .lo(lim_lo), .hi(lim_hi), .out_of_range(oor));

  lux_persist_map #(.PCODE_W(PCODE_W), .CNT_W(CW)) u_map (
    .code(persist_code), .target(target));

  lux_streak #(.CNT_W(CW)) u_streak (
    .clk(clk), .rst_n(rst_n), .take(take), .oor(oor),
    .target(target), .reached(reached));

  assign fire = take & ((persist_code == '0) | reached);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       irq_flag <= 1'b0;
    else if (fire)    irq_flag <= 1'b1;   // trigger beats clear
    else if (irq_clr) irq_flag <= 1'b0;
  end

  assign irq_od_n = ~(irq_flag & irq_en);

  AST_FIRE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> irq_flag); // R9
  AST_CLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_clr && !fire) |=> !irq_flag); // R8
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (!fire && !irq_clr) |=> $stable(irq_flag)); // R8
  AST_CODE0_EVERY: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && persist_code == '0) |=> irq_flag); // R4
  AST_NO_PULL_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_flag |-> irq_od_n); // R10
endmodule

// File: tb/sim_lux_alarm.sv
module sim_lux_alarm;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        smp_valid = 1'b0, smp_ready;
  logic [15:0] smp_level = '0, lim_lo = '0, lim_hi = '0;
  logic [3:0]  persist_code = '0;
  logic        irq_en = 1'b0, irq_clr = 1'b0;
  logic        irq_flag, irq_od_n;

  int n_run = 0, n_fail = 0;
  int m_cnt = 0;
  bit m_flag = 0;
  bit done = 0;

  always #2 clk = ~clk;

  lux_alarm u0 (.clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_ready(smp_ready),
    .smp_level(smp_level), .lim_lo(lim_lo), .lim_hi(lim_hi), .persist_code(persist_code),
    .irq_en(irq_en), .irq_clr(irq_clr), .irq_flag(irq_flag), .irq_od_n(irq_od_n));

  function automatic bit oor_f(logic [15:0] v, logic [15:0] lo, logic [15:0] hi);
    if (v < lo) return 1;
    if (lo > hi) return 0;
    return v > hi;
  endfunction

  function automatic int target_f(logic [3:0] c);
    return (c <= 3) ? int'(c) : (int'(c) - 3) * 5;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Called at a negedge: drive, take the edge, update model, check at next negedge.
  task automatic cyc(string tag, bit vld, logic [15:0] v, bit clr);
    bit o, fire;
    smp_valid = vld; smp_level = v; irq_clr = clr;
    @(posedge clk);
    fire = 0;
    if (vld) begin
      o = oor_f(v, lim_lo, lim_hi);
      m_cnt = o ? ((m_cnt == 63) ? 63 : m_cnt + 1) : 0;
      fire = (persist_code == 0) || (o && m_cnt >= target_f(persist_code));
    end
    if (fire) m_flag = 1; else if (clr) m_flag = 0;
    @(negedge clk);
    smp_valid = 0; irq_clr = 0;
    check({tag, " flag"}, 32'(irq_flag), 32'(m_flag));
    check({tag, " od_n"}, 32'(irq_od_n), 32'(!(m_flag && irq_en)));
    check("R1 ready", 32'(smp_ready), 32'd1);
  endtask

  task automatic clear_all();
    cyc("R8", 0, 16'd0, 1);
    for (int i = 0; i < 2; i++) cyc("R7", 1, lim_lo, 0);
  endtask

  function automatic logic [15:0] pick();
    case ($urandom % 5)
      0: return lim_lo - 16'd1;
      1: return lim_lo;
      2: return lim_hi;
      3: return lim_hi + 16'd1;
      default: return 16'($urandom);
    endcase
  endfunction

  initial begin
    #400000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd12345));
    repeat (3) @(negedge clk);
    check("R12 flag", 32'(irq_flag), 32'd0);
    check("R12 od_n", 32'(irq_od_n), 32'd1);
    rst_n = 1;
    @(negedge clk);
    irq_en = 1; lim_lo = 16'd100; lim_hi = 16'd200;

    // R5: code 2 needs two in a row; R11 flag visible after strobe
    persist_code = 2;
    cyc("R5", 1, 16'd99, 0);
    cyc("R11", 1, 16'd201, 0);
    clear_all();
    // R7: in-range value breaks the run
    cyc("R7", 1, 16'd50, 0); cyc("R7", 1, 16'd100, 0); cyc("R7", 1, 16'd300, 0);
    // R2: equality is in range
    cyc("R2", 1, 16'd200, 0); cyc("R2", 1, 16'd100, 0);
    // R1: idle cycles do not count
    cyc("R1", 1, 16'd0, 0); cyc("R1", 0, 16'd0, 0); cyc("R1", 0, 16'd0, 0);
    cyc("R1", 1, 16'd0, 0);
    clear_all();
    // R6: code 4 -> 5
    persist_code = 4;
    for (int i = 0; i < 5; i++) cyc("R6", 1, 16'd5000, 0);
    clear_all();
    // R3: crossed limits ignore the upper test
    lim_lo = 16'd300; lim_hi = 16'd50; persist_code = 1;
    cyc("R3", 1, 16'd1000, 0); cyc("R3", 1, 16'd299, 0);
    clear_all();
    // R4: code 0 fires on in-range data
    lim_lo = 16'd10; lim_hi = 16'd20; persist_code = 0;
    cyc("R4", 1, 16'd15, 0);
    clear_all();
    // R9: trigger with clear on same edge
    persist_code = 1;
    cyc("R9", 1, 16'd0, 1);
    // R10: status independent of enable
    irq_en = 0; cyc("R10", 0, 16'd0, 0);
    irq_en = 1; cyc("R10", 0, 16'd0, 0);
    clear_all();
    // R13: code 15, 60 then beyond saturation
    persist_code = 15;
    for (int i = 0; i < 70; i++) cyc("R13", 1, 16'd0, i >= 60);
    clear_all();

    // random mix
    for (int i = 0; i < 3000; i++) begin
      if (i % 50 == 0) begin
        lim_lo = 16'($urandom); lim_hi = 16'($urandom);
        persist_code = 4'($urandom); irq_en = 1'($urandom);
      end
      cyc("R2 rnd", ($urandom % 4) != 0, pick(), ($urandom % 6) == 0);
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule